// File: doc/BRIEF.md
# Quad DAC Serial Register Controller

This block is the digital front end of a four-channel voltage-output DAC. A host writes 16-bit command frames over a three-wire serial port with chip select, serial clock and data in, and a serial data out pin. The port's pins are sampled by the block's own system clock. Each frame carries a 4-bit command in its top nibble and a 12-bit data field below it. The command selects one of several operations. It can write a channel's staging (input) register, its active register, or both. It can copy every staging register to the active registers at once. It can also set the global settling mode, the per-channel shutdown impedance and two general-purpose I/O bits.

Two straps are sampled during reset. One chooses which serial clock edge captures data. The other chooses the code that every register takes after reset. The active codes drive the converters. A variant with lower resolution keeps the upper bits of each word, and the low bits of the field act as ignored sub-bits. Serial data out shifts out the previous frame, so several devices can be chained. After a GPIO read request, it instead carries the readback of the input pins.

Top module: `qdac_ctrl`

## Requirements
- R1: A frame is taken MSB first, with the command in bits [15:12] and the data in bits [11:0]. It executes on the rising edge of chip select only if exactly 16 capture edges occurred while chip select was low. Frames of 15 or 17 bits leave every output unchanged.
- R2: Chip select may stay low across a pause between two 8-bit packets, and the frame still executes as one 16-bit word.
- R3: `edge_rise_i` is sampled at reset. A value of 1 captures data on the rising edge of the serial clock, and 0 captures on the falling edge.
- R4: `pu_sel_i` is sampled at reset and sets both registers of every channel. The encodings are 00 = 0x000, 10 = 0xFFF, and 01 or 11 = 0x800. The codes are valid from the first clock after reset is released.
- R5: Commands 0x0 to 0x3 write the staging register of channel 0 to 3. The active code does not change.
- R6: Commands 0x4 to 0x7 write both registers of channel 0 to 3 with the data field.
- R7: Commands 0x8 to 0xB write only the active register of channel 0 to 3. The staging register keeps its value.
- R8: Command 0xC copies all four staging registers to the active registers.
- R9: Command 0xD sets `fast_o` to data bit 0. Its reset value is 0 (slow).
- R10: Command 0xE sets `sd_hiz_o` to data bits [3:0]. Bit n belongs to channel n, where 1 means high impedance and 0 means 1 kΩ. Its reset value is 0.
- R11: Command 0xF with data bit 11 at 0 sets `gpio_o` to data [1:0] and `gpio_oe_o` to data [3:2]. With data bit 11 at 1, it changes nothing and loads {4'hF, 10'b0, gpio_i} for output on the next frame.
- R12: `sdo_o` presents the previous frame's 16 bits MSB first. The first bit is valid before the first capture edge, and each later bit is valid after the preceding capture edge.
- R13: Each channel's code output is the top DAC_BITS bits of its 12-bit active word. The remaining low bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples the serial port |
| rst_ni | input | 1 | Asynchronous reset, active low |
| edge_rise_i | input | 1 | Capture edge strap, 1 = rising |
| pu_sel_i | input | 2 | Reset code strap |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| gpio_i | input | 2 | GPIO pin readback |
| gpio_o | output | 2 | GPIO output values |
| gpio_oe_o | output | 2 | GPIO output enables |
| fast_o | output | 1 | Settling mode, 1 = fast |
| sd_hiz_o | output | 4 | Per-channel shutdown impedance select |
| code_o | output | 4*DAC_BITS | Active codes, channel n at [n*DAC_BITS +: DAC_BITS] |

## Verification
The bench sends frames of 15 and 17 bits. A counter that only checks "at least 16" would execute the long frame, and one that does not wait for the count would execute the short one. It writes a staging register and then reveals it through a copy. It also writes an active register alone and copies afterwards. A design that mixes up the two registers would change the code too early or restore the wrong value. It splits a frame into two packets with chip select held low, and it repeats a write in falling-edge mode. It chains frames and then a GPIO read to check that data out carries the previous word rather than the current one. A second instance with 8-bit resolution checks that the upper bits are kept.

// File: rtl/qdac_pkg.sv
`timescale 1ns/1ps
package qdac_pkg;
  localparam int FRAME_W = 16;
  localparam int CMD_W   = 4;
  localparam int DATA_W  = 12;
  localparam int NCH     = 4;
  localparam int GPIO_W  = 2;
  localparam int GPIO_RD_BIT = 11;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [DATA_W-1:0] data;
  } frame_t;

  localparam logic [CMD_W-1:0] CMD_IN_BASE   = 4'h0;
  localparam logic [CMD_W-1:0] CMD_BOTH_BASE = 4'h4;
  localparam logic [CMD_W-1:0] CMD_ACT_BASE  = 4'h8;
  localparam logic [CMD_W-1:0] CMD_COPY      = 4'hC;
  localparam logic [CMD_W-1:0] CMD_MODE      = 4'hD;
  localparam logic [CMD_W-1:0] CMD_SHDN      = 4'hE;
  localparam logic [CMD_W-1:0] CMD_GPIO      = 4'hF;

  function automatic logic [DATA_W-1:0] pu_code(input logic [1:0] sel);
    case (sel)
      2'b00:   return '0;
      2'b10:   return '1;
      default: return {1'b1, {(DATA_W-1){1'b0}}};
    endcase
  endfunction
endpackage

// File: rtl/qdac_serial_rx.sv
`timescale 1ns/1ps
module qdac_serial_rx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               edge_rise_i,
  input  logic               cs_ni,
  input  logic               sclk_i,
  input  logic               sdi_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] load_val_i,
  output logic               sdo_o,
  output logic               frm_valid_o,
  output logic [FRAME_W-1:0] frm_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [1:0] cs_sync, sclk_sync, sdi_sync;
  logic       cs_d, sclk_d;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sync   <= 2'b11;
      sclk_sync <= 2'b00;
      sdi_sync  <= 2'b00;
      cs_d      <= 1'b1;
      sclk_d    <= 1'b0;
    end else begin
      cs_sync   <= {cs_sync[0], cs_ni};
      sclk_sync <= {sclk_sync[0], sclk_i};
      sdi_sync  <= {sdi_sync[0], sdi_i};
      cs_d      <= cs_sync[1];
      sclk_d    <= sclk_sync[1];
    end
  end

  logic cap, shift, cs_rise;
  assign cap     = edge_rise_i ? (sclk_sync[1] & ~sclk_d) : (~sclk_sync[1] & sclk_d);
  assign shift   = cap & ~cs_sync[1];
  assign cs_rise = cs_sync[1] & ~cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      sh_q        <= '0;
      frm_valid_o <= 1'b0;
    end else begin
      frm_valid_o <= cs_rise && (cnt_q == CNT_FULL);
      if (cs_rise) cnt_q <= '0;
      else if (shift && cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      if (load_i) sh_q <= load_val_i;
      else if (shift) sh_q <= {sh_q[FRAME_W-2:0], sdi_sync[1]};
    end
  end

  assign sdo_o = sh_q[FRAME_W-1];
  assign frm_o = sh_q;
endmodule

// File: rtl/qdac_chan.sv
`timescale 1ns/1ps
module qdac_chan #(
  parameter int REG_W    = 12,
  parameter int DAC_BITS = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_i,
  input  logic [REG_W-1:0]    init_val_i,
  input  logic                wr_in_i,
  input  logic                wr_act_i,
  input  logic                copy_i,
  input  logic [REG_W-1:0]    data_i,
  output logic [REG_W-1:0]    in_o,
  output logic [DAC_BITS-1:0] code_o
);
  logic [REG_W-1:0]    in_q;
  logic [DAC_BITS-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      act_q <= '0;
    end else if (init_i) begin
      in_q  <= init_val_i;
      act_q <= init_val_i[REG_W-1 -: DAC_BITS];
    end else begin
      if (wr_in_i) in_q <= data_i;
      if (wr_act_i)    act_q <= data_i[REG_W-1 -: DAC_BITS];
      else if (copy_i) act_q <= in_q[REG_W-1 -: DAC_BITS];
    end
  end

  assign in_o   = in_q;
  assign code_o = act_q;
endmodule

// File: rtl/qdac_ctrl.sv
`timescale 1ns/1ps
module qdac_ctrl
  import qdac_pkg::*;
#(
  parameter int DAC_BITS = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    edge_rise_i,
  input  logic [1:0]              pu_sel_i,
  input  logic                    cs_ni,
  input  logic                    sclk_i,
  input  logic                    sdi_i,
  output logic                    sdo_o,
  input  logic [GPIO_W-1:0]       gpio_i,
  output logic [GPIO_W-1:0]       gpio_o,
  output logic [GPIO_W-1:0]       gpio_oe_o,
  output logic                    fast_o,
  output logic [NCH-1:0]          sd_hiz_o,
  output logic [NCH*DAC_BITS-1:0] code_o
);
  logic init_q, edge_q;
  logic [GPIO_W-1:0] gpio_s1, gpio_s2;

  // init_q stays high through reset and the first clock after it; straps load then
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= 1'b1;
      edge_q  <= 1'b1;
      gpio_s1 <= '0;
      gpio_s2 <= '0;
    end else begin
      init_q  <= 1'b0;
      if (init_q) edge_q <= edge_rise_i;
      gpio_s1 <= gpio_i;
      gpio_s2 <= gpio_s1;
    end
  end

  logic               frm_valid;
  logic [FRAME_W-1:0] frm_raw;
  frame_t             frm;
  logic               rd_load;
  logic [FRAME_W-1:0] rd_val;

  assign frm     = frame_t'(frm_raw);
  assign rd_load = frm_valid && frm.cmd == CMD_GPIO && frm.data[GPIO_RD_BIT];
  assign rd_val  = {CMD_GPIO, {(DATA_W-GPIO_W){1'b0}}, gpio_s2};

  qdac_serial_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_rise_i (init_q ? edge_rise_i : edge_q),
    .cs_ni       (cs_ni),
    .sclk_i      (sclk_i),
    .sdi_i       (sdi_i),
    .load_i      (rd_load),
    .load_val_i  (rd_val),
    .sdo_o       (sdo_o),
    .frm_valid_o (frm_valid),
    .frm_o       (frm_raw)
  );

  logic [DATA_W-1:0]     init_val;
  logic [NCH*DATA_W-1:0] in_code;
  logic                  copy_all;

  assign init_val = pu_code(pu_sel_i);
  assign copy_all = frm_valid && frm.cmd == CMD_COPY;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr_in, wr_both, wr_act;
    assign wr_in   = frm_valid && frm.cmd == CMD_IN_BASE   + CMD_W'(c);
    assign wr_both = frm_valid && frm.cmd == CMD_BOTH_BASE + CMD_W'(c);
    assign wr_act  = frm_valid && frm.cmd == CMD_ACT_BASE  + CMD_W'(c);

    qdac_chan #(.REG_W(DATA_W), .DAC_BITS(DAC_BITS)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .init_i     (init_q),
      .init_val_i (init_val),
      .wr_in_i    (wr_in | wr_both),
      .wr_act_i   (wr_act | wr_both),
      .copy_i     (copy_all),
      .data_i     (frm.data),
      .in_o       (in_code[c*DATA_W +: DATA_W]),
      .code_o     (code_o[c*DAC_BITS +: DAC_BITS])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_o    <= 1'b0;
      sd_hiz_o  <= '0;
      gpio_o    <= '0;
      gpio_oe_o <= '0;
    end else if (frm_valid) begin
      if (frm.cmd == CMD_MODE) fast_o <= frm.data[0];
      if (frm.cmd == CMD_SHDN) sd_hiz_o <= frm.data[NCH-1:0];
      if (frm.cmd == CMD_GPIO && !frm.data[GPIO_RD_BIT]) begin
        gpio_o    <= frm.data[GPIO_W-1:0];
        gpio_oe_o <= frm.data[2*GPIO_W-1:GPIO_W];
      end
    end
  end
endmodule

// File: rtl/qdac_ctrl_chk.sv
`timescale 1ns/1ps
module qdac_ctrl_chk
  import qdac_pkg::*;
#(
  parameter int DAC_BITS = 12
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    init_i,
  input logic                    frm_valid_i,
  input logic [CMD_W-1:0]        frm_cmd_i,
  input logic [DATA_W-1:0]       frm_data_i,
  input logic [NCH*DATA_W-1:0]   in_code_i,
  input logic [NCH*DAC_BITS-1:0] code_i,
  input logic                    fast_i,
  input logic [NCH-1:0]          sd_hiz_i,
  input logic [GPIO_W-1:0]       gpio_out_i,
  input logic [GPIO_W-1:0]       gpio_oe_i
);
  a_r1_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i |=> !frm_valid_i);

  a_r1_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frm_valid_i && !init_i) |=> ($stable(code_i) && $stable(in_code_i)));

  a_r9_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frm_valid_i && frm_cmd_i == CMD_MODE) |=> $stable(fast_i));

  a_r10_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_valid_i |=> ($stable(sd_hiz_i) && $stable(gpio_out_i) && $stable(gpio_oe_i)));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    a_r5_in_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_valid_i && frm_cmd_i == CMD_IN_BASE + CMD_W'(c))
      |=> ($stable(code_i[c*DAC_BITS +: DAC_BITS])
           && in_code_i[c*DATA_W +: DATA_W] == $past(frm_data_i)));

    a_r6_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_valid_i && frm_cmd_i == CMD_BOTH_BASE + CMD_W'(c))
      |=> (code_i[c*DAC_BITS +: DAC_BITS] == $past(frm_data_i[DATA_W-1 -: DAC_BITS])
           && in_code_i[c*DATA_W +: DATA_W] == $past(frm_data_i)));

    a_r7_act_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_valid_i && frm_cmd_i == CMD_ACT_BASE + CMD_W'(c))
      |=> $stable(in_code_i[c*DATA_W +: DATA_W]));

    a_r8_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_valid_i && frm_cmd_i == CMD_COPY)
      |=> code_i[c*DAC_BITS +: DAC_BITS]
          == $past(in_code_i[c*DATA_W + DATA_W - 1 -: DAC_BITS]));
  end
endmodule

bind qdac_ctrl qdac_ctrl_chk #(.DAC_BITS(DAC_BITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_i      (init_q),
  .frm_valid_i (frm_valid),
  .frm_cmd_i   (frm.cmd),
  .frm_data_i  (frm.data),
  .in_code_i   (in_code),
  .code_i      (code_o),
  .fast_i      (fast_o),
  .sd_hiz_i    (sd_hiz_o),
  .gpio_out_i  (gpio_o),
  .gpio_oe_i   (gpio_oe_o)
);

// File: tb/qdac_ctrl_bench.sv
`timescale 1ns/1ps
module qdac_ctrl_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, edge_rise, cs_n, sclk, sdi;
  logic [1:0] pu_sel, gpio_in;
  logic       sdo, fast, sdo8, fast8;
  logic [1:0] gpio_out, gpio_oe, gpio_out8, gpio_oe8;
  logic [3:0] sd_hiz, sd_hiz8;
  logic [47:0] code;
  logic [31:0] code8;

  qdac_ctrl u_qdac_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .edge_rise_i(edge_rise), .pu_sel_i(pu_sel),
    .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo),
    .gpio_i(gpio_in), .gpio_o(gpio_out), .gpio_oe_o(gpio_oe),
    .fast_o(fast), .sd_hiz_o(sd_hiz), .code_o(code));

  qdac_ctrl #(.DAC_BITS(8)) u_qdac_ctrl_b8 (
    .clk_i(clk), .rst_ni(rst_n), .edge_rise_i(edge_rise), .pu_sel_i(pu_sel),
    .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo8),
    .gpio_i(gpio_in), .gpio_o(gpio_out8), .gpio_oe_o(gpio_oe8),
    .fast_o(fast8), .sd_hiz_o(sd_hiz8), .code_o(code8));

  int n_chk = 0, n_bad = 0;
  logic rise_mode = 1'b1;
  logic [15:0] sdo_cap = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ch(input int i);
    return 32'(code[i*12 +: 12]);
  endfunction

  task automatic do_reset(input logic e, input logic [1:0] p);
    rst_n = 1'b0; edge_rise = e; pu_sel = p; rise_mode = e;
    cs_n = 1'b1; sclk = ~e; sdi = 1'b0;
    #40 rst_n = 1'b1;
    #40;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int k = n - 1; k >= 0; k--) begin
      sdi = v[k];
      #20 sdo_cap = {sdo_cap[14:0], sdo};
      sclk = rise_mode;
      #20 sclk = ~rise_mode;
    end
  endtask

  task automatic frame_n(input logic [31:0] v, input int n);
    cs_n = 1'b0;
    #20 send_bits(v, n);
    #20 cs_n = 1'b1;
    #100;
  endtask

  task automatic frame(input logic [15:0] v);
    frame_n(32'(v), 16);
  endtask

  task automatic t_reset_states();
    do_reset(1'b1, 2'b00);
    for (int i = 0; i < 4; i++) check("R4 zero scale", ch(i), 32'h000);
    check("R9 fast reset", 32'(fast), 0);
    check("R10 shutdown reset", 32'(sd_hiz), 0);
    check("R11 gpio reset", 32'({gpio_oe, gpio_out}), 0);
    do_reset(1'b1, 2'b10);
    for (int i = 0; i < 4; i++) check("R4 full scale", ch(i), 32'hFFF);
    check("R13 8-bit full scale", 32'(code8[7:0]), 32'hFF);
    do_reset(1'b1, 2'b01);
    for (int i = 0; i < 4; i++) check("R4 midscale", ch(i), 32'h800);
  endtask

  task automatic t_double_buffer();
    frame(16'h1ABC);
    check("R5 staging write leaves active", ch(1), 32'h800);
    frame(16'hC000);
    check("R8 copy ch1", ch(1), 32'hABC);
    check("R8 copy ch0", ch(0), 32'h800);
    frame(16'h6123);
    check("R6 write both", ch(2), 32'h123);
    frame(16'hB456);
    check("R7 active only", ch(3), 32'h456);
    frame(16'hC000);
    check("R7 staging kept ch3", ch(3), 32'h800);
    check("R6 staging written ch2", ch(2), 32'h123);
  endtask

  task automatic t_config();
    frame(16'hD001);
    check("R9 fast set", 32'(fast), 1);
    frame(16'hD000);
    check("R9 fast clear", 32'(fast), 0);
    frame(16'hE005);
    check("R10 shutdown bits", 32'(sd_hiz), 32'h5);
    frame(16'hF00E);
    check("R11 gpio out", 32'(gpio_out), 32'h2);
    check("R11 gpio oe", 32'(gpio_oe), 32'h3);
    gpio_in = 2'b01;
    frame(16'hF800);
    check("R11 read keeps config", 32'({gpio_oe, gpio_out}), 32'hE);
    frame(16'hD000);
    check("R11 readback on sdo", 32'(sdo_cap), 32'hF001);
  endtask

  task automatic t_daisy();
    frame(16'h59A5);
    check("R1 load both ch1", ch(1), 32'h9A5);
    frame(16'hD000);
    check("R12 previous frame on sdo", 32'(sdo_cap), 32'h59A5);
  endtask

  task automatic t_length();
    frame_n(32'h4777 >> 1, 15);
    check("R1 short frame dropped", ch(0), 32'h800);
    frame_n(32'h04777, 17);
    check("R1 long frame dropped", ch(0), 32'h800);
    frame(16'h4777);
    check("R1 exact frame runs", ch(0), 32'h777);
  endtask

  task automatic t_packets();
    cs_n = 1'b0;
    #20 send_bits(32'h7A, 8);
    #200 send_bits(32'hCE, 8);
    #20 cs_n = 1'b1;
    #100;
    check("R2 two packets", ch(3), 32'hACE);
    check("R13 8-bit keeps top bits", 32'(code8[31:24]), 32'hAC);
  endtask

  task automatic t_falling();
    do_reset(1'b0, 2'b00);
    check("R4 zero after re-reset", ch(3), 32'h000);
    frame(16'h73C3);
    check("R3 falling edge capture", ch(3), 32'h3C3);
    frame(16'h0155);
    frame(16'hC000);
    check("R3 falling edge second frame", ch(0), 32'h155);
  endtask

  initial begin
    rst_n = 1'b0; edge_rise = 1'b1; pu_sel = 2'b00; cs_n = 1'b1;
    sclk = 1'b0; sdi = 1'b0; gpio_in = 2'b00;
    t_reset_states();
    t_double_buffer();
    t_config();
    t_daisy();
    t_length();
    t_packets();
    t_falling();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule